// File: doc/BRIEF.md
# Dual-Channel Quadrature Position Decoder

This block turns the two-phase pulse trains of two optical incremental encoders into two position counts. Each channel receives an in-phase and a quadrature signal. The channel can take them from one of two pin sets, or it can ignore both. The pins are passed through a register synchronizer. Each legal Gray-code step then moves that channel's count up or down by one. A step in which both phases change together is discarded and recorded as an error.

The count runs modulo 256 by default. A single control bit switches both channels to modulo 1024 at run time. Each time a count wraps, in either direction, a sticky pending bit is set. When the channel's interrupt enable is set, that pending bit drives the shared interrupt line.

Software uses a small word-addressed register port. It can read the status, read and write the control word, read each count, and clear each count. Reading the status word clears the sticky bits.

Top module: `quad_pos_decoder`

## Requirements
- R1: A pin change is not counted until it has passed through SYNC_STAGES (default 2) register stages. With the default, a change set up before rising edge E1 leaves the count unchanged after edge E2, and the new count is visible after edge E3.
- R2: The phase pair {I,Q} stepping 00 -> 10 -> 11 -> 01 -> 00 (I leads) adds one to the count on each step.
- R3: The reverse order 00 -> 01 -> 11 -> 10 -> 00 (Q leads) subtracts one on each step.
- R4: A step in which I and Q both change leaves the count unchanged. It sets the channel's error bit, which is status bit NCH+c (bit 2 for channel 0 and bit 3 for channel 1).
- R5: In narrow mode (control bit 6 = 0), counting up from 0xFF gives 0x00 and counting down from 0x00 gives 0xFF. Either wrap sets the channel's pending bit, which is status bit c.
- R6: In wide mode (control bit 6 = 1), the wraps happen at 0x3FF and 0x000 instead. Passing from 0xFF to 0x100 sets no pending bit. Returning to narrow mode truncates the count to its low 8 bits.
- R7: `irq` is high exactly when some channel c has its pending bit set and its enable, control bit 4+c, set.
- R8: A read of the status word (address 0) returns the pending bits and the error bits, and then clears them. An event that arrives in the same cycle is kept.
- R9: Writing address 2+c with wdata bit 0 = 1 sets count c to zero. This takes priority over a step in the same cycle and leaves the other channel's count alone. A write with bit 0 = 0 changes nothing.
- R10: Control bits [2c+1:2c] choose the source for channel c: 01 selects pin set A, 10 selects pin set B, and 00 or 11 disables the channel. While a channel is disabled its count holds. The pin set that is not selected has no effect.
- R11: After reset, the status word, the control word, both counts and `irq` are all zero.
- R12: Address 1 reads back the control word. Address 2+c reads count c, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a_i | input | NCH | In-phase pins, set A, one per channel |
| enc_a_q | input | NCH | Quadrature pins, set A |
| enc_b_i | input | NCH | In-phase pins, set B |
| enc_b_q | input | NCH | Quadrature pins, set B |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (only side effect: status clear) |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Wrap interrupt request |

## Verification
The decoder is driven with a forward rotation, a reverse rotation, reversals in the middle of a rotation, and diagonal double-changes placed between legal steps. This tells apart correct direction decoding, a swapped phase order, and a double change that is miscounted instead of rejected. The wrap logic is tested at both ends of the range in both widths. A 256-step climb in wide mode separates the 8-bit and 10-bit wrap points. Pin activity on the unselected set and on a disabled channel shows whether the source selection isolates the pins it should ignore.

// File: rtl/qd_pkg.sv
package qd_pkg;

    localparam int NARROW_W = 8;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_CTRL   = 1;
    localparam int ADDR_COUNT0 = 2;

    // encoding equals (position difference mod 4)
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_BAD  = 2'd2,
        ST_DOWN = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        SRC_OFF     = 2'd0,
        SRC_A       = 2'd1,
        SRC_B       = 2'd2,
        SRC_OFF_ALT = 2'd3
    } src_e;

    typedef struct packed {
        src_e src;
        logic irq_en;
    } chan_cfg_t;

    typedef struct packed {
        logic wrap;
        logic err;
    } chan_evt_t;

    // position of a {I,Q} pair along the forward rotation
    function automatic logic [1:0] gray_pos(input logic [1:0] iq);
        case (iq)
            2'b00:   gray_pos = 2'd0;
            2'b10:   gray_pos = 2'd1;
            2'b11:   gray_pos = 2'd2;
            default: gray_pos = 2'd3;
        endcase
    endfunction

    function automatic step_e classify(input logic [1:0] prev, input logic [1:0] cur);
        logic [1:0] diff;
        diff = gray_pos(cur) - gray_pos(prev);
        classify = step_e'(diff);
    endfunction

endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qd_channel.sv
module qd_channel
    import qd_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       iq_a_i,
    input  logic [1:0]       iq_b_i,
    input  src_e             src_i,
    input  logic             wide_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output chan_evt_t        evt_o
);
    localparam logic [CNT_W-1:0] WIDE_MAX   = '1;
    localparam logic [CNT_W-1:0] NARROW_MAX = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] ONE        = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [1:0]       iq_sel, iq_prev;
    logic             active;
    step_e            step;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_max, cnt_view;

    always_comb begin
        iq_sel  = (src_i == SRC_B) ? iq_b_i : iq_a_i;
        active  = (src_i == SRC_A) || (src_i == SRC_B);
        step    = classify(iq_prev, iq_sel);
        cnt_max = wide_i ? WIDE_MAX : NARROW_MAX;
        cnt_view = cnt_q & cnt_max;
    end

    always_comb begin
        cnt_d     = cnt_view;
        evt_o     = '0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (active) begin
            case (step)
                ST_UP: begin
                    if (cnt_view == cnt_max) begin
                        cnt_d      = '0;
                        evt_o.wrap = 1'b1;
                    end else begin
                        cnt_d = cnt_view + ONE;
                    end
                end
                ST_DOWN: begin
                    if (cnt_view == '0) begin
                        cnt_d      = cnt_max;
                        evt_o.wrap = 1'b1;
                    end else begin
                        cnt_d = cnt_view - ONE;
                    end
                end
                ST_BAD:  evt_o.err = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            iq_prev <= '0;
        end else begin
            cnt_q   <= cnt_d;
            iq_prev <= iq_sel;
        end
    end

    assign cnt_o = cnt_view;

    assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
        (active && step == ST_UP && !clr_i && cnt_view != cnt_max)
        |=> cnt_q == $past(cnt_view) + ONE);

    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        (active && step == ST_DOWN && !clr_i && cnt_view != '0)
        |=> cnt_q == $past(cnt_view) - ONE);

    assert_bad_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (active && step == ST_BAD && !clr_i) |=> cnt_q == $past(cnt_view));

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (active && step == ST_UP && !clr_i && cnt_view == cnt_max) |=> cnt_q == '0);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);

    assert_off_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!active && !clr_i) |=> cnt_q == $past(cnt_view));
endmodule

// File: rtl/qd_csr.sv
module qd_csr
    import qd_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 10,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  chan_evt_t         evt_i [NCH],
    input  logic [CNT_W-1:0]  cnt_i [NCH],
    output chan_cfg_t         cfg_o [NCH],
    output logic              wide_o,
    output logic [NCH-1:0]    clr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int CTRL_W   = 3 * NCH + 1;
    localparam int WIDE_BIT = 3 * NCH;
    localparam int STAT_W   = 2 * NCH;

    logic [CTRL_W-1:0] ctrl_q;
    logic [NCH-1:0]    pend_q, err_q, wrap_v, err_v, irq_en_v;
    logic              status_rd;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i;
    assign status_rd    = rd_i && (addr_i == ADDR_W'(ADDR_STATUS));
    assign wide_o       = ctrl_q[WIDE_BIT];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign wrap_v[c]        = evt_i[c].wrap;
        assign err_v[c]         = evt_i[c].err;
        assign irq_en_v[c]      = ctrl_q[2*NCH + c];
        assign cfg_o[c].src     = src_e'(ctrl_q[2*c +: 2]);
        assign cfg_o[c].irq_en  = irq_en_v[c];
        assign clr_o[c]         = wr_i && (addr_i == ADDR_W'(ADDR_COUNT0 + c)) && wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pend_q <= '0;
            err_q  <= '0;
        end else begin
            if (wr_i && addr_i == ADDR_W'(ADDR_CTRL)) ctrl_q <= wdata_i[CTRL_W-1:0];
            pend_q <= (status_rd ? '0 : pend_q) | wrap_v;
            err_q  <= (status_rd ? '0 : err_q)  | err_v;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADDR_STATUS)) rdata_o[STAT_W-1:0] = {err_q, pend_q};
        if (addr_i == ADDR_W'(ADDR_CTRL))   rdata_o[CTRL_W-1:0] = ctrl_q;
        for (int c = 0; c < NCH; c++) begin
            if (addr_i == ADDR_W'(ADDR_COUNT0 + c)) rdata_o[CNT_W-1:0] = cnt_i[c];
        end
    end

    assign irq_o = |(pend_q & irq_en_v);

    assert_rd_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (status_rd && wrap_v == '0 && err_v == '0) |=> (pend_q == '0 && err_q == '0));

    assert_wrap_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (|wrap_v) |=> (|pend_q));

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!(|wrap_v) && status_rd && !wr_i) |=> !irq_o);
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
    import qd_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    enc_a_i,
    input  logic [NCH-1:0]    enc_a_q,
    input  logic [NCH-1:0]    enc_b_i,
    input  logic [NCH-1:0]    enc_b_q,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int PIN_W = 4 * NCH;

    logic [PIN_W-1:0] pins_sync;
    logic [NCH-1:0]   a_i_s, a_q_s, b_i_s, b_q_s, clr;
    logic             wide;
    chan_cfg_t        cfg [NCH];
    chan_evt_t        evt [NCH];
    logic [CNT_W-1:0] cnt [NCH];

    qd_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({enc_b_i, enc_b_q, enc_a_i, enc_a_q}),
        .q_o (pins_sync)
    );

    assign a_q_s = pins_sync[NCH-1:0];
    assign a_i_s = pins_sync[2*NCH-1:NCH];
    assign b_q_s = pins_sync[3*NCH-1:2*NCH];
    assign b_i_s = pins_sync[4*NCH-1:3*NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        qd_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .iq_a_i ({a_i_s[c], a_q_s[c]}),
            .iq_b_i ({b_i_s[c], b_q_s[c]}),
            .src_i  (cfg[c].src),
            .wide_i (wide),
            .clr_i  (clr[c]),
            .cnt_o  (cnt[c]),
            .evt_o  (evt[c])
        );
    end

    qd_csr #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .evt_i   (evt),
        .cnt_i   (cnt),
        .cfg_o   (cfg),
        .wide_o  (wide),
        .clr_o   (clr),
        .rdata_o (bus_rdata),
        .irq_o   (irq)
    );
endmodule

// File: tb/quad_pos_decoder_tb.sv
module quad_pos_decoder_tb;
    localparam int NCH = 2;
    localparam int DW  = 16;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
    logic           bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    quad_pos_decoder u_dut (
        .clk(clk), .rst(rst),
        .enc_a_i(a_i), .enc_a_q(a_q), .enc_b_i(b_i), .enc_b_q(b_q),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // [11:10] kind (0 up, 1 down, 2 double change), [9:8] {I,Q}, [7:0] expected count
    localparam logic [11:0] VEC [12] = '{
        12'h201, 12'h302, 12'h103, 12'h004,
        12'h503, 12'h702, 12'h601, 12'h400,
        12'hB00, 12'h101, 12'hA01, 12'h400
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input int addr, output logic [DW-1:0] d);
        bus_addr = AW'(addr);
        #1 d = bus_rdata;
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(addr); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_status(output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(0); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input int ch, input bit use_b, input logic [1:0] iq);
        @(negedge clk);
        if (use_b) begin b_i[ch] = iq[1]; b_q[ch] = iq[0]; end
        else       begin a_i[ch] = iq[1]; a_q[ch] = iq[0]; end
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [1:0] nxt(input logic [1:0] c, input bit up);
        if (up) case (c) 2'b00: nxt = 2'b10; 2'b10: nxt = 2'b11; 2'b11: nxt = 2'b01; default: nxt = 2'b00; endcase
        else    case (c) 2'b00: nxt = 2'b01; 2'b01: nxt = 2'b11; 2'b11: nxt = 2'b10; default: nxt = 2'b00; endcase
    endfunction

    task automatic move(input int ch, input bit use_b, input bit up);
        logic [1:0] cur;
        cur = use_b ? {b_i[ch], b_q[ch]} : {a_i[ch], a_q[ch]};
        set_pins(ch, use_b, nxt(cur, up));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        peek(0, d); check("R11 status", d, 16'h0000);
        peek(1, d); check("R11 ctrl", d, 16'h0000);
        peek(2, d); check("R11 count0", d, 16'h0000);
        peek(3, d); check("R11 count1", d, 16'h0000);
        check("R11 irq", {15'd0, irq}, 16'h0000);

        wr(1, 16'h0001);
        peek(1, d); check("R12 ctrl readback", d, 16'h0001);

        // R1 synchronizer latency
        @(negedge clk);
        a_i[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        peek(2, d); check("R1 not yet counted", d, 16'h0000);
        @(negedge clk);
        peek(2, d); check("R1 counted on third edge", d, 16'h0001);
        set_pins(0, 0, 2'b00);
        peek(2, d); check("R3 step back", d, 16'h0000);

        // table walk: R2 R3 R4
        for (int k = 0; k < 12; k++) begin
            set_pins(0, 0, VEC[k][9:8]);
            peek(2, d);
            case (VEC[k][11:10])
                2'd0:    check("R2 forward step", d, {8'd0, VEC[k][7:0]});
                2'd1:    check("R3 reverse step", d, {8'd0, VEC[k][7:0]});
                default: check("R4 double change", d, {8'd0, VEC[k][7:0]});
            endcase
        end
        rd_status(d); check("R4 error flag ch0", d, 16'h0004);
        rd_status(d); check("R8 status cleared by read", d, 16'h0000);

        // R10 source selection
        move(0, 1, 1);
        peek(2, d); check("R10 set B ignored", d, 16'h0000);
        set_pins(0, 1, 2'b00);
        wr(1, 16'h0002);
        move(0, 1, 1);
        peek(2, d); check("R10 set B counted", d, 16'h0001);
        wr(1, 16'h0000);
        move(0, 0, 1);
        peek(2, d); check("R10 disabled holds", d, 16'h0001);

        // R5 narrow wrap and R7 interrupt
        wr(1, 16'h0004);
        move(1, 0, 0);
        peek(3, d); check("R5 underflow to 0xFF", d, 16'h00FF);
        check("R7 irq masked", {15'd0, irq}, 16'h0000);
        wr(1, 16'h0024);
        check("R7 irq enabled", {15'd0, irq}, 16'h0001);
        rd_status(d); check("R5 pending ch1", d, 16'h0002);
        check("R8 irq after read", {15'd0, irq}, 16'h0000);
        move(1, 0, 1);
        peek(3, d); check("R5 overflow to 0x00", d, 16'h0000);
        rd_status(d); check("R5 pending on overflow", d, 16'h0002);

        // R9 clear
        repeat (3) move(1, 0, 1);
        wr(1, 16'h0025);
        repeat (2) move(0, 0, 1);
        peek(2, d); check("R9 ch0 before", d, 16'h0003);
        wr(3, 16'h0001);
        peek(3, d); check("R9 ch1 cleared", d, 16'h0000);
        peek(2, d); check("R9 ch0 untouched", d, 16'h0003);
        wr(2, 16'h0000);
        peek(2, d); check("R9 bit0 zero no clear", d, 16'h0003);

        // R6 wide mode
        wr(1, 16'h0065);
        rd_status(d);
        move(1, 0, 0);
        peek(3, d); check("R6 wide underflow", d, 16'h03FF);
        rd_status(d); check("R6 wide pending", d, 16'h0002);
        move(1, 0, 1);
        peek(3, d); check("R6 wide overflow", d, 16'h0000);
        rd_status(d);
        for (int k = 0; k < 256; k++) move(1, 0, 1);
        peek(3, d); check("R6 passes 0xFF", d, 16'h0100);
        rd_status(d); check("R6 no wrap at 0xFF", d, 16'h0000);
        wr(1, 16'h0025);
        peek(3, d); check("R6 truncate to narrow", d, 16'h0000);
        move(1, 0, 1);
        peek(3, d); check("R6 narrow after switch", d, 16'h0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule